// File: doc/BRIEF.md
# Shared-Stage Slot Booker

This block prevents two instructions from reaching one shared pipeline stage, such as the memory stage, in the same cycle when they come from execution units of different latencies. It keeps one bit for each future cycle that the shared stage can still be booked for. The decode stage presents an instruction's opcode. A small fixed table turns the opcode into the number of cycles until that instruction would enter the shared stage. The block then looks at the bit for that cycle.

If the slot is free, the block books it and the instruction proceeds. If the slot is already taken, the block raises a stall for fetch and decode, and books nothing. Every cycle the whole vector moves one place toward bit 0, whether or not a stall is in effect. The booked bit that blocks a stalled instruction therefore moves out of the checked position, and the instruction goes ahead on a later cycle. An opcode whose latency the vector cannot represent raises an error output and is not booked.

Top module: `stage_slot_booker`

## Requirements
- R1: A synchronous active-low reset clears every bit of `resv_vec`. While `dec_valid` is low after reset, `fetch_stall` stays 0.
- R2: Every cycle in which nothing is booked, `resv_vec` becomes its previous value shifted right by one place, with 0 entering bit 7.
- R3: The opcode gives the latency in cycles as follows: 0→2, 1→3, 2→4, 3→6, 4→8, 5→9, 6→1, 7→11.
- R4: Bit i of `resv_vec` stands for the cycle i+2 cycles after the current one. A valid instruction of latency L checks bit L-2, and `fetch_stall` is high in that same cycle exactly when that bit is 1.
- R5: A valid, supported instruction that finds its bit at 0 books the slot. On the next cycle bit L-3 of `resv_vec` is 1, together with the shifted earlier contents. For L=2 the next vector is only the shifted vector.
- R6: While `fetch_stall` is high, no bit is booked, and the next `resv_vec` is the shifted current vector.
- R7: An instruction held at decode while stalled proceeds once the blocking booking has shifted past its checked position. At that point it books the slot at its own latency.
- R8: A valid opcode whose latency lies outside 2..9 drives `lat_err` high in the same cycle, with `fetch_stall` low, and books nothing.
- R9: With `dec_valid` low, `fetch_stall` and `lat_err` are low and nothing is booked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | An instruction is present at decode |
| dec_op | input | 3 | Opcode class of the decode instruction |
| fetch_stall | output | 1 | Holds fetch and decode this cycle |
| lat_err | output | 1 | The valid opcode has an unsupported latency |
| resv_vec | output | 8 | Booking vector, bit i = cycle i+2 ahead |

## Verification
The assertions check on every cycle that the vector shifts by one place when nothing is booked, and that a stalled cycle books nothing. They also check that a booking lands one place below its checked index, that an error never comes with a stall, that an idle decode leaves both flags low, and that reset leaves the vector empty. Other behaviours can only be shown by the bench's scenarios, which compare against a model that tracks bookings by absolute cycle number. These are the opcode latency table, a conflict between back-to-back instructions of adjacent latencies, the release of a held instruction after the blocking bit has passed, and long mixed streams.

// File: rtl/ssr_pkg.sv
// Package: shared constants and the fixed opcode-to-latency table.
// Assumes a 3-bit opcode class. Latencies outside the vector's reach
// are kept in the table on purpose, so that the error path is exercised.
package ssr_pkg;
    localparam int OP_W  = 3;
    localparam int LAT_W = 4;

    // Map an opcode class to its latency in cycles until the shared stage.
    function automatic logic [LAT_W-1:0] op_latency(input logic [OP_W-1:0] op);
        logic [LAT_W-1:0] l;
        case (op)
            3'd0:    l = 4'd2;
            3'd1:    l = 4'd3;
            3'd2:    l = 4'd4;
            3'd3:    l = 4'd6;
            3'd4:    l = 4'd8;
            3'd5:    l = 4'd9;
            3'd6:    l = 4'd1;
            default: l = 4'd11;
        endcase
        return l;
    endfunction
endpackage

// File: rtl/ssr_lat_decode.sv
// Latency decode: turns an opcode into a latency, checks that latency
// against the range the booking vector covers, and forms the bit index.
// Assumes LAT_MIN is the latency that maps to bit 0.
module ssr_lat_decode #(
    parameter int OP_W    = ssr_pkg::OP_W,
    parameter int LAT_W   = ssr_pkg::LAT_W,
    parameter int VEC_W   = 8,
    parameter int LAT_MIN = 2,
    localparam int IDX_W  = $clog2(VEC_W),
    localparam int LAT_MAX = LAT_MIN + VEC_W - 1
) (
    input  logic [OP_W-1:0]  op,
    output logic             in_range,
    output logic [IDX_W-1:0] idx
);
    logic [LAT_W-1:0] lat;
    logic [LAT_W-1:0] ofs;

    // Look up latency and derive range flag and vector index.
    always_comb begin
        lat      = ssr_pkg::op_latency(op);
        in_range = (int'(lat) >= LAT_MIN) && (int'(lat) <= LAT_MAX);
        ofs      = lat - LAT_W'(LAT_MIN);
        idx      = ofs[IDX_W-1:0];
    end
endmodule

// File: rtl/ssr_slot_check.sv
// Slot check: reads the booking bit selected by the decode index and
// decides between stall, booking or error for the current cycle.
// Assumes idx is meaningful only when in_range is high.
module ssr_slot_check #(
    parameter int VEC_W  = 8,
    localparam int IDX_W = $clog2(VEC_W)
) (
    input  logic             valid,
    input  logic             in_range,
    input  logic [IDX_W-1:0] idx,
    input  logic [VEC_W-1:0] rv,
    output logic             stall,
    output logic             claim,
    output logic             err
);
    logic busy;

    // Select the bit for the target cycle and classify the request.
    always_comb begin
        busy  = rv[idx];
        err   = valid && !in_range;
        stall = valid && in_range && busy;
        claim = valid && in_range && !busy;
    end
endmodule

// File: rtl/ssr_resv_vec.sv
// Booking vector register: shifts toward bit 0 every cycle, with zero
// entering the top. A booking at index k is written at k-1 so that it
// still names the same absolute cycle after the shift. A booking at
// index 0 falls off the vector, because no later request can reach it.
module ssr_resv_vec #(
    parameter int VEC_W  = 8,
    localparam int IDX_W = $clog2(VEC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             claim,
    input  logic [IDX_W-1:0] idx,
    output logic [VEC_W-1:0] rv
);
    logic [VEC_W-1:0] rv_nxt;

    // Per-bit next state: upper neighbour plus an adjusted booking.
    for (genvar i = 0; i < VEC_W; i++) begin : g_bit
        if (i == VEC_W - 1) begin : g_top
            assign rv_nxt[i] = 1'b0;
        end else begin : g_mid
            assign rv_nxt[i] = rv[i+1] | (claim && (int'(idx) == i + 1));
        end
    end

    // State register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) rv <= '0;
        else        rv <= rv_nxt;
    end

    // R2
    shift_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !claim |=> rv == ($past(rv) >> 1));

    // R5
    book_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && idx != '0) |=>
        rv == (($past(rv) >> 1) | (VEC_W'(1) << ($past(idx) - 1'b1))));

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> rv == '0);
endmodule

// File: rtl/stage_slot_booker.sv
// Top: books the shared stage for decode instructions by latency and
// stalls fetch/decode on a collision. Assumes the decode stage holds
// the same instruction on its inputs while fetch_stall is high.
module stage_slot_booker #(
    parameter int VEC_W   = 8,
    parameter int LAT_MIN = 2,
    localparam int OP_W   = ssr_pkg::OP_W,
    localparam int IDX_W  = $clog2(VEC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid,
    input  logic [OP_W-1:0]  dec_op,
    output logic             fetch_stall,
    output logic             lat_err,
    output logic [VEC_W-1:0] resv_vec
);
    logic             in_range;
    logic [IDX_W-1:0] idx;
    logic             claim;

    ssr_lat_decode #(.VEC_W(VEC_W), .LAT_MIN(LAT_MIN)) u_dec (
        .op(dec_op), .in_range(in_range), .idx(idx)
    );

    ssr_slot_check #(.VEC_W(VEC_W)) u_chk (
        .valid(dec_valid), .in_range(in_range), .idx(idx), .rv(resv_vec),
        .stall(fetch_stall), .claim(claim), .err(lat_err)
    );

    ssr_resv_vec #(.VEC_W(VEC_W)) u_vec (
        .clk(clk), .rst_n(rst_n), .claim(claim), .idx(idx), .rv(resv_vec)
    );

    // R6
    stall_nobook_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |=> resv_vec == ($past(resv_vec) >> 1));

    // R8
    err_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lat_err |-> !fetch_stall);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!fetch_stall && !lat_err));

    // R4
    stall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |-> resv_vec != '0);
endmodule

// File: tb/tb_stage_slot_booker.sv
module tb_stage_slot_booker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dec_valid = 1'b0;
    logic [2:0] dec_op = '0;
    logic       fetch_stall, lat_err;
    logic [7:0] resv_vec;

    int total = 0;
    int bad = 0;
    int t = 0;
    bit booked [0:8191];
    bit done = 0;
    logic exp_stall_last;

    always #10 clk = ~clk;

    stage_slot_booker dut (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_op(dec_op),
        .fetch_stall(fetch_stall), .lat_err(lat_err), .resv_vec(resv_vec)
    );

    // Latency table as stated in R3.
    function automatic int ref_lat(input logic [2:0] op);
        int tbl [8] = '{2, 3, 4, 6, 8, 9, 1, 11};
        return tbl[op];
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < 8192; i++) booked[i] = 1'b0;
        t = 0;
    endtask

    // One decode cycle: drive, compare against model, advance.
    task automatic step(input logic v, input logic [2:0] op, input string tag);
        int L;
        logic e_err, e_stall;
        logic [7:0] e_rv;
        dec_valid = v;
        dec_op = op;
        #1;
        L = ref_lat(op);
        e_err = v && (L < 2 || L > 9);
        e_stall = v && !e_err && booked[t + L];
        for (int i = 0; i < 8; i++) e_rv[i] = booked[t + 2 + i];
        chk(tag, "resv_vec", int'(resv_vec), int'(e_rv));
        chk(tag, "fetch_stall", int'(fetch_stall), int'(e_stall));
        chk(tag, "lat_err", int'(lat_err), int'(e_err));
        if (v && !e_err && !e_stall) booked[t + L] = 1'b1;
        exp_stall_last = e_stall;
        @(posedge clk);
        t++;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        dec_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        clear_model();
    endtask

    // Hold an instruction at decode until it is no longer stalled.
    task automatic issue_hold(input logic [2:0] op, input string tag);
        int n = 0;
        step(1'b1, op, tag);
        while (exp_stall_last && n < 20) begin
            step(1'b1, op, tag);
            n++;
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=expired expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] lfsr = 8'hA5;
        do_reset();
        // R1 reset state and R9 idle
        step(1'b0, 3'd0, "R1");
        step(1'b0, 3'd5, "R9");
        // R5 and R2: one long booking observed while shifting
        step(1'b1, 3'd5, "R5");
        for (int i = 0; i < 9; i++) step(1'b0, 3'd0, "R2");
        // R3 each supported opcode alone, then watch it
        for (int op = 0; op < 6; op++) begin
            step(1'b1, 3'(op), "R3");
            for (int k = 0; k < 3; k++) step(1'b0, 3'd0, "R3");
        end
        // R4 R6 R7: lat3 then lat2 next cycle collides, then retries
        step(1'b1, 3'd1, "R4");
        step(1'b1, 3'd0, "R6");
        step(1'b1, 3'd0, "R7");
        for (int i = 0; i < 4; i++) step(1'b0, 3'd0, "R2");
        // R7: lat9 then lat8 collides, held until it goes
        step(1'b1, 3'd5, "R5");
        issue_hold(3'd4, "R7");
        for (int i = 0; i < 10; i++) step(1'b0, 3'd0, "R2");
        // R8 unsupported latencies
        step(1'b1, 3'd6, "R8");
        step(1'b1, 3'd7, "R8");
        step(1'b0, 3'd7, "R9");
        // R1 mid-run reset with bookings present
        step(1'b1, 3'd5, "R5");
        step(1'b1, 3'd3, "R5");
        do_reset();
        step(1'b0, 3'd0, "R1");
        // Mixed stream with holds on stall
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (lfsr[7:6] == 2'b00) step(1'b0, lfsr[2:0], "R9");
            else issue_hold(lfsr[2:0], "R4");
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule